// File: doc/BRIEF.md
# Fractional N/32 Clock Rate Controller

This block turns a free-running input clock into a clock-enable stream whose average rate is a programmable fraction of the input. Time is cut into frames of 32 input cycles. Within each frame the block passes `m` cycles and swallows the rest, so the output rate is input rate × m / 32. Software does not write `m` directly. It writes a 5-bit swallow code `c`, and the block uses m = 32 − c. Code 0 passes every cycle. Code 31 passes one cycle in 32.

Each passed cycle appears as a one-cycle-high `clk_en` pulse. The pulse can drive a clock-gating cell or act as a clock enable for downstream logic. An accumulator adds `m` modulo 32 on every input cycle and passes the cycle on each carry, which spreads the passed cycles evenly through the frame.

A new code is written into a pending register and has no effect until software sets a commit flag. The flag reads as 1 while the change is outstanding. The block copies the pending code into the active setting at the next frame boundary, then clears the flag one cycle later. Software polls the flag and must not start another change while it is set.

Top module: `frac_rate_ctl`

## Requirements
- R1: After synchronous reset the rate register reads 0, the commit flag reads 0, and `clk_en` is high on every cycle (full rate).
- R2: The register at address 0 keeps the pending swallow code in bits 12:8. All of its other bits read 0. Any address other than 0 and 1 reads 0.
- R3: Writing a word with bit 31 set to address 1 while the commit flag is clear sets the flag. The flag reads back as bit 31 of address 1 in the next cycle.
- R4: Writing a word with bit 31 clear to address 1 has no effect. The flag stays 0 and the output rate stays unchanged.
- R5: The pending code becomes active only at a frame boundary, so no frame mixes two rates. The commit flag falls in the cycle after the new frame's first cycle. Frames are aligned to the first cycle after reset.
- R6: While a code `c` is active, every 32-cycle frame contains exactly 32 − c `clk_en` pulses.
- R7: The distance between consecutive `clk_en` pulses is always floor(32/m) or ceil(32/m) cycles.
- R8: Writing the pending code without a commit does not change the output. A second commit write while the flag is set is ignored, and the change still completes at one boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being rate-reduced |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read (when `bus_sel` is high) |
| bus_addr | input | ADDR_W (4) | Word address: 0 = rate register, 1 = commit register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| clk_en | output | 1 | One-cycle pulse for each input cycle that is passed |

## Verification
A frame counter out of step with reset shows at the ports as a commit-flag fall that is not one cycle past a multiple of 32. That fault is visible within one frame of the first commit. An accumulator that is not zero at frame start shows up within a frame as gaps between pulses outside the floor/ceil bound, or as a wrong pulse count in a 32-cycle window. A commit flag that fails to clear shows up as a poll that never returns 0. A commit flag that sets on the wrong write shows up as a nonzero read, or as a rate change that software never requested.

// File: rtl/frac_rate_pkg.sv
package frac_rate_pkg;

    localparam int CODE_W    = 5;
    localparam int FRAME_LEN = 1 << CODE_W;
    localparam int MULT_W    = CODE_W + 1;
    localparam int DATA_W    = 32;

    typedef logic [CODE_W-1:0] rate_code_t;
    typedef logic [MULT_W-1:0] mult_t;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_RATE,
        REG_KICK
    } reg_sel_e;

    typedef struct packed {
        logic              wr_en;
        reg_sel_e          target;
        logic [DATA_W-1:0] wdata;
    } bus_op_t;

    // passed cycles per frame for a given swallow code
    function automatic mult_t mult_of(rate_code_t code);
        return mult_t'(FRAME_LEN) - mult_t'(code);
    endfunction

endpackage

// File: rtl/frac_rate_regs.sv
module frac_rate_regs
    import frac_rate_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int RATE_ADDR = 0,
    parameter int KICK_ADDR = 1,
    parameter int CODE_LSB  = 8,
    parameter int KICK_BIT  = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              commit_done_i,
    output rate_code_t        pend_code_o,
    output logic              kick_o
);

    bus_op_t    op;
    rate_code_t pend_q;
    logic       kick_q;

    always_comb begin
        op.wr_en  = bus_sel & bus_wr;
        op.wdata  = bus_wdata;
        op.target = REG_NONE;
        if (bus_sel) begin
            if (bus_addr == ADDR_W'(RATE_ADDR))      op.target = REG_RATE;
            else if (bus_addr == ADDR_W'(KICK_ADDR)) op.target = REG_KICK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            kick_q <= 1'b0;
        end else begin
            if (op.wr_en && op.target == REG_RATE)
                pend_q <= op.wdata[CODE_LSB +: CODE_W];
            if (commit_done_i)
                kick_q <= 1'b0;
            else if (op.wr_en && op.target == REG_KICK && op.wdata[KICK_BIT] && !kick_q)
                kick_q <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (op.target)
            REG_RATE: bus_rdata[CODE_LSB +: CODE_W] = pend_q;
            REG_KICK: bus_rdata[KICK_BIT]           = kick_q;
            default:  bus_rdata                     = '0;
        endcase
    end

    assign pend_code_o = pend_q;
    assign kick_o      = kick_q;

    // R3
    kick_set_by_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(kick_q) |-> $past(op.wr_en && op.target == REG_KICK && op.wdata[KICK_BIT]));

    // R5
    kick_clear_after_commit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(kick_q) |-> $past(commit_done_i));

    // R4
    kick_zero_write_chk: assert property (@(posedge clk) disable iff (rst)
        (op.wr_en && op.target == REG_KICK && !op.wdata[KICK_BIT] && !kick_q) |=> !kick_q);

endmodule

// File: rtl/frac_rate_frame.sv
module frac_rate_frame
    import frac_rate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       kick_i,
    input  rate_code_t pend_code_i,
    output rate_code_t active_code_o,
    output logic       frame_first_o,
    output logic       commit_done_o
);

    rate_code_t phase_q;
    rate_code_t active_q;
    logic       done_q;
    logic       frame_last;

    assign frame_last = (phase_q == rate_code_t'(FRAME_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= '0;
            active_q <= '0;
            done_q   <= 1'b0;
        end else begin
            phase_q <= phase_q + 1'b1;
            done_q  <= 1'b0;
            if (frame_last && kick_i && !done_q) begin
                active_q <= pend_code_i;
                done_q   <= 1'b1;
            end
        end
    end

    assign active_code_o = active_q;
    assign frame_first_o = (phase_q == '0);
    assign commit_done_o = done_q;

    // R5
    active_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q != $past(active_q)) |-> $past(frame_last));

endmodule

// File: rtl/frac_rate_accum.sv
module frac_rate_accum
    import frac_rate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rate_code_t active_code_i,
    input  logic       frame_first_i,
    output logic       clk_en_o
);

    rate_code_t acc_q;
    mult_t      mult;
    mult_t      sum;

    assign mult     = mult_of(active_code_i);
    assign sum      = mult_t'(acc_q) + mult;
    assign clk_en_o = (sum >= mult_t'(FRAME_LEN));

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= sum[CODE_W-1:0];
    end

    // R7
    frame_phase_chk: assert property (@(posedge clk) disable iff (rst)
        frame_first_i |-> (acc_q == '0));

endmodule

// File: rtl/frac_rate_ctl.sv
module frac_rate_ctl
    import frac_rate_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int RATE_ADDR = 0,
    parameter int KICK_ADDR = 1,
    parameter int CODE_LSB  = 8,
    parameter int KICK_BIT  = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              clk_en
);

    rate_code_t pend_code;
    rate_code_t active_code;
    logic       kick;
    logic       frame_first;
    logic       commit_done;

    frac_rate_regs #(
        .ADDR_W   (ADDR_W),
        .RATE_ADDR(RATE_ADDR),
        .KICK_ADDR(KICK_ADDR),
        .CODE_LSB (CODE_LSB),
        .KICK_BIT (KICK_BIT)
    ) u_regs (
        .clk          (clk),
        .rst          (rst),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .commit_done_i(commit_done),
        .pend_code_o  (pend_code),
        .kick_o       (kick)
    );

    frac_rate_frame u_frame (
        .clk          (clk),
        .rst          (rst),
        .kick_i       (kick),
        .pend_code_i  (pend_code),
        .active_code_o(active_code),
        .frame_first_o(frame_first),
        .commit_done_o(commit_done)
    );

    frac_rate_accum u_accum (
        .clk          (clk),
        .rst          (rst),
        .active_code_i(active_code),
        .frame_first_i(frame_first),
        .clk_en_o     (clk_en)
    );

endmodule

// File: tb/frac_rate_ctl_tb.sv
module frac_rate_ctl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        clk_en;

    int checks = 0;
    int errors = 0;
    int ncyc = 0;
    bit hist [0:8191];

    frac_rate_ctl u_dut (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .clk_en   (clk_en)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (!rst && ncyc < 8192) begin
            hist[ncyc] = clk_en;
            ncyc++;
        end
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL R5 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int count_pulses(input int s, input int n);
        int c = 0;
        for (int i = s; i < s + n; i++) if (hist[i]) c++;
        return c;
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        bus_read(4'd0, v);
        check(v == 32'h0, "R1", "rate reg after reset", v, 0);
        bus_read(4'd1, v);
        check(v == 32'h0, "R1", "commit flag after reset", v, 0);
        bus_sel = 1'b0;
        wait_cycles(34);
        check(count_pulses(0, 32) == 32, "R1", "pulses in first frame",
              count_pulses(0, 32), 32);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        int s0;
        bus_write(4'd0, 32'hFFFF_FFFF);
        bus_read(4'd0, v);
        check(v == 32'h0000_1F00, "R2", "rate field only", v, 32'h1F00);
        bus_write(4'd0, 32'h0000_0A00);
        bus_read(4'd0, v);
        check(v == 32'h0000_0A00, "R2", "rate readback", v, 32'h0A00);
        bus_read(4'd2, v);
        check(v == 32'h0, "R2", "unmapped address", v, 0);
        bus_write(4'd0, 32'h0000_1F00);
        bus_sel = 1'b0;
        s0 = ncyc;
        wait_cycles(40);
        check(count_pulses(s0, 32) == 32, "R8", "rate unchanged without commit",
              count_pulses(s0, 32), 32);
    endtask

    task automatic t_kick_zero();
        logic [31:0] v;
        int s0;
        bus_write(4'd0, 32'h0000_1400);
        bus_write(4'd1, 32'h7FFF_FFFF);
        bus_read(4'd1, v);
        check(v == 32'h0, "R4", "flag after zero write", v, 0);
        bus_sel = 1'b0;
        s0 = ncyc;
        wait_cycles(70);
        check(count_pulses(s0, 64) == 64, "R4", "rate after zero write",
              count_pulses(s0, 64), 64);
    endtask

    task automatic t_change(input int code, input int old_m);
        logic [31:0] v;
        int m, c, s, prev, lo, hi, bad;
        bit found;
        m = 32 - code;
        lo = 32 / m;
        hi = (32 + m - 1) / m;
        bus_write(4'd0, 32'(code) << 8);
        bus_write(4'd1, 32'h8000_0000);
        bus_read(4'd1, v);
        check(v == 32'h8000_0000, "R3", "flag set after commit", v, 32'h8000_0000);
        bus_write(4'd1, 32'h8000_0000);
        bus_read(4'd1, v);
        check(v == 32'h8000_0000, "R8", "flag after repeated commit", v, 32'h8000_0000);
        found = 1'b0;
        c = 0;
        for (int i = 0; i < 200 && !found; i++) begin
            bus_read(4'd1, v);
            if (v == 32'h0) begin
                found = 1'b1;
                c = ncyc - 1;
            end
        end
        bus_sel = 1'b0;
        check(found, "R5", "flag cleared", found, 1);
        s = c - 1;
        check((s % 32) == 0, "R5", "frame start alignment", s % 32, 0);
        wait_cycles(70);
        check(count_pulses(s - 32, 32) == old_m, "R5", "old frame unmixed",
              count_pulses(s - 32, 32), old_m);
        check(count_pulses(s, 32) == m, "R6", "pulses in new frame",
              count_pulses(s, 32), m);
        check(count_pulses(s + 32, 32) == m, "R6", "pulses in next frame",
              count_pulses(s + 32, 32), m);
        prev = -1;
        bad = 0;
        for (int j = s; j < s + 64; j++) begin
            if (hist[j]) begin
                if (prev >= 0 && ((j - prev) < lo || (j - prev) > hi)) bad = j - prev;
                prev = j;
            end
        end
        check(bad == 0, "R7", "pulse spacing", bad, lo);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_regs();
        t_kick_zero();
        t_change(20, 32);
        t_change(31, 12);
        t_change(16, 1);
        t_change(7, 16);
        t_change(0, 25);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule